// File: doc/BRIEF.md
# Packet Commit Write-Log Unit

This block gathers the side effects produced by one two-slot instruction packet and makes them visible together when the packet commits. While the packet executes, it logs register writes, predicate writes, branch targets and store requests from slot 0 and slot 1. It also keeps a per-slot cancel mask that is built up during the packet. A one-cycle start pulse opens each packet and wipes the previous packet's log.

When `commit` is accepted, the unit registers the surviving register writes, the merged predicate values and the next PC onto a set of commit outputs for one cycle (`cm_valid`). It then walks the logged stores onto a simple valid/ready memory request port. Slot 0 goes first and one store is sent per accepted handshake. A slot-0 load request (`ld_req`) is held off with `ld_go` low while slot 1 holds a live store. That store is sent to memory first, so the load sees its effect.

Top module: `pcw_commit`

## Requirements
- R1: A predicate write keeps only bits [7:0] of the 32-bit written value. Predicate `n` appears at `cm_pred_val[8n+7:8n]` and its written flag at `cm_pred_wr[n]`. A predicate nobody wrote shows flag 0 and value 0.
- R2: If the same predicate is written more than once in a packet, from one slot or from both, its committed value is the bitwise AND of all the writes from uncancelled slots.
- R3: Only the first taken branch of a packet sets `cm_next_pc`, and later branch targets are ignored. With no taken branch, `cm_next_pc` equals `seq_pc` and `cm_br_taken` is 0.
- R4: A store request whose size is not 1, 2, 4 or 8 bytes raises `bad_size` in the same cycle and is not logged. No memory request ever carries such a size.
- R5: A store in a slot whose cancel bit is set (bit 0 = slot 0, bit 1 = slot 1) is never sent to memory.
- R6: While `ld_req` is high and slot 1 holds a live (uncancelled, not yet sent) store, `ld_go` stays low and that store is presented on the memory port. `ld_go` rises in the cycle after the store's handshake. If slot 1 has no live store, `ld_go` follows `ld_req` at once.
- R7: `mem_data` carries the low 8 bits of the 32-bit data for size 1, the low 16 bits for size 2 and all 32 bits for size 4, each zero-extended. For size 8 it carries the separate 64-bit data.
- R8: After commit, live stores are sent slot 0 first and then slot 1, one per handshake. While `mem_ready` is low, `mem_valid` and `mem_addr` hold.
- R9: A slot-1 store that was already sent early for a load is not sent again at commit.
- R10: `cm_valid` pulses for one cycle, one cycle after a `commit` that is accepted while not busy. Register and predicate writes from cancelled slots are dropped from the commit outputs (`cm_rw_en` bit s for slot s).
- R11: `pkt_start` clears every written flag, the branch-taken flag, the store log and the cancel mask. Writes presented in the same cycle count as the first of the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_start | input | 1 | Opens a new packet, clears the log |
| cancel_set | input | 2 | Sets cancel bits for slot 0 / slot 1 |
| seq_pc | input | AW | Fall-through PC |
| rw_en | input | 1 | Register write strobe |
| rw_slot | input | 1 | Slot of register write |
| rw_num | input | RNW | Register index |
| rw_val | input | 32 | Register value |
| pw_en | input | 1 | Predicate write strobe |
| pw_slot | input | 1 | Slot of predicate write |
| pw_num | input | PNW | Predicate index |
| pw_val | input | 32 | Predicate value (low byte kept) |
| br_en | input | 1 | Taken-branch strobe |
| br_target | input | AW | Branch target |
| st_en | input | 1 | Store log strobe |
| st_slot | input | 1 | Slot of store |
| st_addr | input | AW | Store address |
| st_size | input | 4 | Store size in bytes |
| st_d32 | input | 32 | Data for 1/2/4-byte stores |
| st_d64 | input | 64 | Data for 8-byte stores |
| ld_req | input | 1 | Slot-0 load wants to read |
| ld_go | output | 1 | Load may read memory |
| commit | input | 1 | Commit the packet |
| busy | output | 1 | Store drain in progress |
| bad_size | output | 1 | Illegal store size seen |
| cm_valid | output | 1 | Commit outputs valid pulse |
| cm_rw_en | output | 2 | Per-slot register write survives |
| cm_rw_num | output | 2*RNW | Per-slot register index |
| cm_rw_val | output | 64 | Per-slot register value |
| cm_pred_wr | output | NPRED | Predicate written flags |
| cm_pred_val | output | 8*NPRED | Merged predicate values |
| cm_br_taken | output | 1 | A branch was taken |
| cm_next_pc | output | AW | Next PC |
| mem_valid | output | 1 | Store request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | AW | Store address |
| mem_size | output | 4 | Store size in bytes |
| mem_data | output | 64 | Store data |

## Verification
The bench goes after the merging of predicate writes, both within one slot and across slots under each cancel pattern. A design that overwrote instead of ANDing, or that let a cancelled slot into the AND, would commit the wrong byte. It checks that a second branch target cannot replace the first and that a later packet without branches falls back to `seq_pc`, which catches a taken flag left over from the previous packet. For stores it stalls the memory port to catch a request that changes under backpressure. It also issues a load against a pending slot-1 store: a design that let the load through early, or that sent the store again at commit, would show a wrong `ld_go` or an extra request. Illegal sizes and cancelled stores must produce no request at all.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int NSLOT = 2;

  function automatic logic size_ok(input logic [3:0] sz);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
  endfunction

  // Shape the memory payload from the logged size
  function automatic logic [63:0] pack_data(input logic [3:0] sz, input logic [31:0] d32,
                                            input logic [63:0] d64);
    case (sz)
      4'd1:    return {56'h0, d32[7:0]};
      4'd2:    return {48'h0, d32[15:0]};
      4'd4:    return {32'h0, d32};
      default: return d64;
    endcase
  endfunction

  // First write loads the byte, later writes AND into it
  function automatic logic [7:0] pred_merge(input logic seen, input logic [7:0] old,
                                            input logic [31:0] v);
    return seen ? (old & v[7:0]) : v[7:0];
  endfunction
endpackage

// File: rtl/pcw_pred_log.sv
module pcw_pred_log
  import pcw_pkg::*;
#(
  parameter int NPRED = 4,
  parameter int PNW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic               slot,
  input  logic [PNW-1:0]     num,
  input  logic [31:0]        val,
  input  logic [NSLOT-1:0]   mask,
  output logic [NPRED-1:0]   res_wr,
  output logic [NPRED*8-1:0] res_val
);
  logic [NSLOT*NPRED-1:0]   seen_f;
  logic [NSLOT*NPRED*8-1:0] pv_f;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar p = 0; p < NPRED; p++) begin : g_pred
      logic       seen_q;
      logic [7:0] pv_q;
      logic       hit;
      assign hit = we && (slot == 1'(s)) && (num == PNW'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seen_q <= 1'b0;
          pv_q   <= 8'h0;
        end else if (hit) begin
          seen_q <= 1'b1;
          pv_q   <= pred_merge(seen_q && !clr, pv_q, val);
        end else if (clr) begin
          seen_q <= 1'b0;
        end
      end

      assign seen_f[s*NPRED+p]       = seen_q;
      assign pv_f[(s*NPRED+p)*8 +: 8] = pv_q;

      AST_PRED_AND: assert property (@(posedge clk) disable iff (!rst_n) hit && seen_q && !clr |=> (pv_q & ~$past(pv_q)) == 8'h0) else $error("later predicate write set a bit"); // R2
    end
  end

  always_comb begin
    res_wr  = '0;
    res_val = '0;
    for (int p = 0; p < NPRED; p++) begin
      logic [7:0] acc;
      acc = 8'hFF;
      for (int s = 0; s < NSLOT; s++) begin
        if (seen_f[s*NPRED+p] && !mask[s]) begin
          res_wr[p] = 1'b1;
          acc       = acc & pv_f[(s*NPRED+p)*8 +: 8];
        end
      end
      if (res_wr[p]) res_val[p*8 +: 8] = acc;
    end
  end
endmodule

// File: rtl/pcw_store_unit.sv
module pcw_store_unit
  import pcw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             st_en,
  input  logic             st_slot,
  input  logic [AW-1:0]    st_addr,
  input  logic [3:0]       st_size,
  input  logic [31:0]      st_d32,
  input  logic [63:0]      st_d64,
  input  logic [NSLOT-1:0] mask,
  input  logic             ld_req,
  input  logic             drain_start,
  output logic             busy,
  output logic             ld_go,
  output logic             bad_size,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [3:0]       mem_size,
  output logic [63:0]      mem_data
);
  logic [NSLOT-1:0]    sv, sdone, live;
  logic [NSLOT*AW-1:0] saddr_f;
  logic [NSLOT*4-1:0]  ssize_f;
  logic [NSLOT*64-1:0] sdat_f;
  logic draining, early_hold, early_req, sel, fire, legal;

  assign legal     = size_ok(st_size);
  assign bad_size  = st_en && !legal;
  assign live      = sv & ~mask & ~sdone;
  assign early_req = ld_req && !draining && live[1];
  assign sel       = draining ? !live[0] : 1'b1;
  assign mem_valid = draining ? (|live) : ((early_req || early_hold) && live[1]);
  assign fire      = mem_valid && mem_ready;
  assign ld_go     = ld_req && !draining && !live[1];
  assign busy      = draining;
  assign mem_addr  = saddr_f[sel*AW +: AW];
  assign mem_size  = ssize_f[sel*4 +: 4];
  assign mem_data  = sdat_f[sel*64 +: 64];

  for (genvar s = 0; s < NSLOT; s++) begin : g_ent
    logic          v_q, done_q;
    logic [AW-1:0] a_q;
    logic [3:0]    z_q;
    logic [63:0]   d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0; done_q <= 1'b0; a_q <= '0; z_q <= '0; d_q <= '0;
      end else if (st_en && legal && (st_slot == 1'(s))) begin
        v_q <= 1'b1; done_q <= 1'b0; a_q <= st_addr; z_q <= st_size;
        d_q <= pack_data(st_size, st_d32, st_d64);
      end else if (clr) begin
        v_q <= 1'b0; done_q <= 1'b0;
      end else if (fire && (sel == 1'(s))) begin
        done_q <= 1'b1;
      end
    end
    assign sv[s]              = v_q;
    assign sdone[s]           = done_q;
    assign saddr_f[s*AW +: AW] = a_q;
    assign ssize_f[s*4 +: 4]   = z_q;
    assign sdat_f[s*64 +: 64]  = d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining   <= 1'b0;
      early_hold <= 1'b0;
    end else begin
      if (!draining && drain_start)  draining <= 1'b1;
      else if (draining && live == '0) draining <= 1'b0;
      if (clr || fire)                early_hold <= 1'b0;
      else if (early_req && !mem_ready) early_hold <= 1'b1;
    end
  end

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> size_ok(mem_size)) else $error("illegal size on memory port"); // R4
  AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n) ld_go |-> !mem_valid) else $error("load released with store outstanding"); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_valid && !mem_ready && !clr && !st_en |=> (mem_valid && $stable(mem_addr)) || !$stable(mask)) else $error("request changed under backpressure"); // R8
endmodule

// File: rtl/pcw_commit.sv
module pcw_commit
  import pcw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int RNW   = 5,
  parameter int NPRED = 4,
  localparam int PNW  = (NPRED > 1) ? $clog2(NPRED) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_start,
  input  logic [1:0]         cancel_set,
  input  logic [AW-1:0]      seq_pc,
  input  logic               rw_en,
  input  logic               rw_slot,
  input  logic [RNW-1:0]     rw_num,
  input  logic [31:0]        rw_val,
  input  logic               pw_en,
  input  logic               pw_slot,
  input  logic [PNW-1:0]     pw_num,
  input  logic [31:0]        pw_val,
  input  logic               br_en,
  input  logic [AW-1:0]      br_target,
  input  logic               st_en,
  input  logic               st_slot,
  input  logic [AW-1:0]      st_addr,
  input  logic [3:0]         st_size,
  input  logic [31:0]        st_d32,
  input  logic [63:0]        st_d64,
  input  logic               ld_req,
  output logic               ld_go,
  input  logic               commit,
  output logic               busy,
  output logic               bad_size,
  output logic               cm_valid,
  output logic [1:0]         cm_rw_en,
  output logic [2*RNW-1:0]   cm_rw_num,
  output logic [63:0]        cm_rw_val,
  output logic [NPRED-1:0]   cm_pred_wr,
  output logic [NPRED*8-1:0] cm_pred_val,
  output logic               cm_br_taken,
  output logic [AW-1:0]      cm_next_pc,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [AW-1:0]      mem_addr,
  output logic [3:0]         mem_size,
  output logic [63:0]        mem_data
);
  logic [NSLOT-1:0]     cmask, rflag;
  logic [NSLOT*RNW-1:0] rnum_f;
  logic [NSLOT*32-1:0]  rval_f;
  logic                 btaken, go;
  logic [AW-1:0]        btgt;
  logic [NPRED-1:0]     pr_wr;
  logic [NPRED*8-1:0]   pr_val;

  assign go = commit && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmask  <= '0;
      btaken <= 1'b0;
      btgt   <= '0;
    end else begin
      cmask <= (pkt_start ? '0 : cmask) | cancel_set;
      if (br_en && !(btaken && !pkt_start)) begin
        btaken <= 1'b1;
        btgt   <= br_target;
      end else if (pkt_start) begin
        btaken <= 1'b0;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_reg
    logic           f_q;
    logic [RNW-1:0] n_q;
    logic [31:0]    v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0; n_q <= '0; v_q <= '0;
      end else if (rw_en && (rw_slot == 1'(s))) begin
        f_q <= 1'b1; n_q <= rw_num; v_q <= rw_val;
      end else if (pkt_start) begin
        f_q <= 1'b0;
      end
    end
    assign rflag[s]               = f_q;
    assign rnum_f[s*RNW +: RNW]   = n_q;
    assign rval_f[s*32 +: 32]     = v_q;
  end

  pcw_pred_log #(.NPRED(NPRED), .PNW(PNW)) u_pred (
    .clk(clk), .rst_n(rst_n), .clr(pkt_start), .we(pw_en), .slot(pw_slot),
    .num(pw_num), .val(pw_val), .mask(cmask), .res_wr(pr_wr), .res_val(pr_val)
  );

  pcw_store_unit #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(pkt_start), .st_en(st_en), .st_slot(st_slot),
    .st_addr(st_addr), .st_size(st_size), .st_d32(st_d32), .st_d64(st_d64),
    .mask(cmask), .ld_req(ld_req), .drain_start(go), .busy(busy), .ld_go(ld_go),
    .bad_size(bad_size), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_valid <= 1'b0; cm_rw_en <= '0; cm_rw_num <= '0; cm_rw_val <= '0;
      cm_pred_wr <= '0; cm_pred_val <= '0; cm_br_taken <= 1'b0; cm_next_pc <= '0;
    end else begin
      cm_valid <= go;
      if (go) begin
        cm_rw_en    <= rflag & ~cmask;
        cm_rw_num   <= rnum_f;
        cm_rw_val   <= rval_f;
        cm_pred_wr  <= pr_wr;
        cm_pred_val <= pr_val;
        cm_br_taken <= btaken;
        cm_next_pc  <= btaken ? btgt : seq_pc;
      end
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cm_valid |=> !cm_valid) else $error("commit pulse longer than a cycle"); // R10
  AST_FIRST_BRANCH: assert property (@(posedge clk) disable iff (!rst_n) br_en && btaken && !pkt_start |=> $stable(btgt)) else $error("later branch replaced target"); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) pkt_start && cancel_set == 2'b00 |=> cmask == '0) else $error("cancel mask survived packet start"); // R11
endmodule

// File: tb/sim_pcw_commit.sv
module sim_pcw_commit;
  localparam int CLK_P = 10;
  localparam int AW = 32, RNW = 5, NPRED = 4, PNW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_start = 0, rw_en = 0, rw_slot = 0, pw_en = 0, pw_slot = 0, br_en = 0;
  logic st_en = 0, st_slot = 0, ld_req = 0, commit = 0, mem_ready = 0;
  logic [1:0] cancel_set = 0;
  logic [AW-1:0] seq_pc = 32'h100, br_target = 0, st_addr = 0;
  logic [RNW-1:0] rw_num = 0;
  logic [PNW-1:0] pw_num = 0;
  logic [31:0] rw_val = 0, pw_val = 0, st_d32 = 0;
  logic [3:0] st_size = 0;
  logic [63:0] st_d64 = 0;
  logic ld_go, busy, bad_size, cm_valid, cm_br_taken, mem_valid;
  logic [1:0] cm_rw_en;
  logic [2*RNW-1:0] cm_rw_num;
  logic [63:0] cm_rw_val, mem_data;
  logic [NPRED-1:0] cm_pred_wr;
  logic [NPRED*8-1:0] cm_pred_val;
  logic [AW-1:0] cm_next_pc, mem_addr;
  logic [3:0] mem_size;

  pcw_commit #(.AW(AW), .RNW(RNW), .NPRED(NPRED)) u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [AW-1:0] ga [4];
  logic [3:0]    gs [4];
  logic [63:0]   gd [4];

  // entry: slotA, valA, slotB, valB, cancel, exp_wr, exp_val
  localparam logic [28:0] PV [6] = '{
    {1'b0, 8'hF0, 1'b0, 8'h3C, 2'b00, 1'b1, 8'h30},
    {1'b0, 8'hF0, 1'b1, 8'h3C, 2'b00, 1'b1, 8'h30},
    {1'b0, 8'hF0, 1'b1, 8'h3C, 2'b01, 1'b1, 8'h3C},
    {1'b0, 8'hF0, 1'b1, 8'h3C, 2'b10, 1'b1, 8'hF0},
    {1'b1, 8'hAA, 1'b1, 8'h0F, 2'b10, 1'b0, 8'h00},
    {1'b1, 8'hFF, 1'b0, 8'h81, 2'b11, 1'b0, 8'h00}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_commit();
    commit = 1; cyc(); commit = 0;
  endtask

  task automatic drain(output int n);
    n = 0; mem_ready = 1;
    for (int k = 0; k < 20 && busy; k++) begin
      if (mem_valid && n < 4) begin ga[n] = mem_addr; gs[n] = mem_size; gd[n] = mem_data; n++; end
      cyc();
    end
    mem_ready = 0;
  endtask

  task automatic store(input logic sl, input logic [31:0] a, input logic [3:0] z,
                       input logic [31:0] d, input logic [63:0] dd);
    st_en = 1; st_slot = sl; st_addr = a; st_size = z; st_d32 = d; st_d64 = dd;
    cyc(); st_en = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    cyc(); cyc(); cyc(); rst_n = 1; cyc();
    chk(!cm_valid && !mem_valid && !busy && !ld_go && !bad_size, "reset", {cm_valid, mem_valid, busy, ld_go}, 0);

    // Predicate merge table (pred 2), first write shares the start cycle (R2, R11)
    foreach (PV[i]) begin
      pkt_start = 1; pw_en = 1; pw_num = 2; pw_slot = PV[i][28]; pw_val = {24'hFFFFFF, PV[i][27:20]};
      cyc(); pkt_start = 0;
      pw_slot = PV[i][19]; pw_val = {24'h0, PV[i][18:11]};
      cyc(); pw_en = 0;
      cancel_set = PV[i][10:9]; cyc(); cancel_set = 0;
      do_commit();
      chk(cm_valid, "R10 pulse", cm_valid, 1);
      chk(cm_pred_wr == {1'b0, PV[i][8], 2'b00}, "R2 wr", cm_pred_wr, {PV[i][8], 2'b00});
      chk(cm_pred_val[23:16] == PV[i][7:0], "R2 val", cm_pred_val[23:16], PV[i][7:0]);
      cyc();
      chk(!cm_valid, "R10 one cycle", cm_valid, 0);
      drain(n);
    end

    // R1 low byte kept
    pkt_start = 1; cyc(); pkt_start = 0;
    pw_en = 1; pw_slot = 0; pw_num = 1; pw_val = 32'h123456A5; cyc(); pw_en = 0;
    do_commit();
    chk(cm_pred_wr == 4'b0010 && cm_pred_val[15:8] == 8'hA5, "R1", cm_pred_val, 64'hA500);
    drain(n);

    // R3 first branch wins, then fall-through after a new packet
    pkt_start = 1; cyc(); pkt_start = 0;
    br_en = 1; br_target = 32'h400; cyc(); br_target = 32'h800; cyc(); br_en = 0;
    do_commit();
    chk(cm_br_taken && cm_next_pc == 32'h400, "R3 first", cm_next_pc, 32'h400);
    drain(n);
    pkt_start = 1; cyc(); pkt_start = 0;
    do_commit();
    chk(!cm_br_taken && cm_next_pc == 32'h100, "R3 R11 fallthru", cm_next_pc, 32'h100);
    drain(n);

    // R10 cancelled slot writes dropped
    pkt_start = 1; rw_en = 1; rw_slot = 0; rw_num = 3; rw_val = 32'hAAAA; cyc(); pkt_start = 0;
    rw_slot = 1; rw_num = 7; rw_val = 32'hBBBB; cyc(); rw_en = 0;
    pw_en = 1; pw_slot = 1; pw_num = 0; pw_val = 32'h55; cyc(); pw_en = 0;
    cancel_set = 2'b10; cyc(); cancel_set = 0;
    do_commit();
    chk(cm_rw_en == 2'b01 && cm_rw_num[4:0] == 5'd3 && cm_rw_val[31:0] == 32'hAAAA, "R10 regs", {cm_rw_en, cm_rw_val[31:0]}, {2'b01, 32'hAAAA});
    chk(cm_pred_wr[0] == 1'b0, "R10 pred", cm_pred_wr, 0);
    drain(n);

    // R4 illegal size flagged and dropped
    pkt_start = 1; cyc(); pkt_start = 0;
    st_en = 1; st_slot = 1; st_addr = 32'h9000; st_size = 4'd5; #1;
    chk(bad_size, "R4 flag", bad_size, 1);
    cyc(); st_en = 0;
    do_commit(); drain(n);
    chk(n == 0, "R4 dropped", n, 0);

    // R7 R8 order, hold and formatting
    pkt_start = 1; cyc(); pkt_start = 0;
    store(0, 32'h1000, 4'd2, 32'hDEADBEEF, 64'h0);
    store(1, 32'h2000, 4'd8, 32'h0, 64'h0123456789ABCDEF);
    do_commit();
    chk(mem_valid && mem_addr == 32'h1000, "R8 first", mem_addr, 32'h1000);
    cyc();
    chk(mem_valid && mem_addr == 32'h1000, "R8 hold", mem_addr, 32'h1000);
    drain(n);
    chk(n == 2, "R8 count", n, 2);
    chk(ga[0] == 32'h1000 && gs[0] == 4'd2 && gd[0] == 64'hBEEF, "R7 half", gd[0], 64'hBEEF);
    chk(ga[1] == 32'h2000 && gs[1] == 4'd8 && gd[1] == 64'h0123456789ABCDEF, "R7 R8 dword", gd[1], 64'h0123456789ABCDEF);

    // R5 cancelled store skipped, R7 byte masking
    pkt_start = 1; cyc(); pkt_start = 0;
    store(0, 32'h3000, 4'd4, 32'h77, 64'h0);
    store(1, 32'h3004, 4'd1, 32'h1FF, 64'h0);
    cancel_set = 2'b01; cyc(); cancel_set = 0;
    do_commit(); drain(n);
    chk(n == 1 && ga[0] == 32'h3004 && gd[0] == 64'hFF, "R5 R7 byte", {n, gd[0]}, 64'hFF);

    // R6 R9 early store for a slot-0 load
    pkt_start = 1; cyc(); pkt_start = 0;
    store(1, 32'h5000, 4'd4, 32'hCAFEF00D, 64'h0);
    store(0, 32'h4000, 4'd4, 32'h11, 64'h0);
    ld_req = 1; #1;
    chk(!ld_go && mem_valid && mem_addr == 32'h5000, "R6 early", mem_addr, 32'h5000);
    cyc();
    chk(!ld_go && mem_valid && mem_addr == 32'h5000, "R6 wait", {ld_go, mem_valid}, 1);
    mem_ready = 1; cyc(); mem_ready = 0;
    chk(ld_go && !mem_valid, "R6 release", {ld_go, mem_valid}, 2);
    ld_req = 0;
    do_commit(); drain(n);
    chk(n == 1 && ga[0] == 32'h4000, "R9 no repeat", n, 1);

    // R5 R6 cancelled slot-1 store does not hold the load
    pkt_start = 1; cyc(); pkt_start = 0;
    store(1, 32'h6000, 4'd4, 32'h1, 64'h0);
    cancel_set = 2'b10; cyc(); cancel_set = 0;
    ld_req = 1; #1;
    chk(ld_go && !mem_valid, "R5 R6 cancelled", {ld_go, mem_valid}, 2);
    cyc(); ld_req = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule